// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a two-channel serial audio stream made of a bit clock, a frame clock and one data line. It turns the stream into parallel left and right samples. All three serial lines are sampled in the system clock domain. The bit clock must be several times slower than the system clock. A 2-bit format code picks one of four framings:

| Code | Format |
|------|--------|
| 00 | right-justified |
| 01 | I2S |
| 10 | left-justified |
| 11 | DSP pulse |

A second 2-bit code sets the word length used in right-justified framing. Both codes come from the control logic beside the block.

Each channel word arrives two's complement with the MSB first, and the left word always comes first. Once a right word has finished, the block presents both samples at once, left-aligned in `SW` bits, together with a one-cycle strobe. Each channel also has a flag that rises after a long unbroken run of all-zero samples. Downstream logic can use that flag to quiet an idle channel.

Top module: `serial_audio_rx`

## Requirements
- R1: With format code 10, a high frame clock marks the left channel, the MSB is the bit sampled on the first rising bit-clock edge after a frame-clock change, and bits are taken on rising edges.
- R2: With format code 01, a low frame clock marks the left channel. The MSB is sampled one bit clock after the frame-clock change, and the bit in the change slot is not captured.
- R3: With format code 00, capture starts at bit position 8, 12 or 16 after the frame-clock change, counting the change slot as position 0. These positions take 24, 20 or 16 bits for length codes 00, 01 and 10. Length code 11 behaves as 00.
- R4: With format code 11, a high frame-clock pulse of at least one bit clock comes before each word, and the word's MSB is the first bit sampled with the frame clock low after the pulse. Bits are taken on falling bit-clock edges. The first pulse after reset marks the left channel, and later pulses alternate between the channels.
- R5: A word shorter than `SW` bits is placed in the upper bits of its output, and the unused low bits read zero.
- R6: In formats 01, 10 and 11, bits of a word beyond the `SW`th are dropped.
- R7: `smp_valid` pulses for one cycle when a right word has ended at the next frame boundary, carrying that right word and the left word before it. No strobe appears before a left word has been fully received after reset, and both sample outputs hold between strobes.
- R8: A channel's zero flag is high exactly when more than `ZERO_FRAMES` consecutive strobed samples of that channel were all zero. The default is 1024. The flag changes only together with a strobe.
- R9: A nonzero sample clears that channel's zero flag and restarts its count at the same strobe that carries it.
- R10: While reset is low, both sample outputs, the strobe and both zero flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | Serial bit clock |
| frm_clk | input | 1 | Frame clock: channel select, or word pulse in format 11 |
| ser_data | input | 1 | Serial data line |
| fmt_mode | input | 2 | Format code: 00 right-justified, 01 I2S, 10 left-justified, 11 DSP pulse |
| rj_len | input | 2 | Right-justified word length: 00 = 24, 01 = 20, 10 = 16, 11 = 24 |
| smp_left | output | SW | Left sample, left-aligned |
| smp_right | output | SW | Right sample, left-aligned |
| smp_valid | output | 1 | One-cycle strobe for a new sample pair |
| zero_left | output | 1 | Left channel long-run zero flag |
| zero_right | output | 1 | Right channel long-run zero flag |

## Verification
The bench sets a 1 in every slot that lies before a word. If the capture window started a slot early, that 1 would appear as the sample MSB: in I2S framing, in all three right-justified offsets, and in the pulse slot of the DSP framing. Words of 28 bits padded with ones catch a design that fails to stop at 24 bits, because its low bits would fill with ones. Short words catch a right-aligned design, which would shift the value down. A design that flushed a half-received channel after reset would emit a strobe the bench does not expect. A zero run one frame longer than the threshold, broken by a single nonzero sample, shows a flag that rises a frame early or late, or one that stays high after the nonzero sample.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int SW          = 24,
  parameter int ZERO_FRAMES = 1024,
  parameter int POS_W       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_clk,
  input  logic          frm_clk,
  input  logic          ser_data,
  input  logic [1:0]    fmt_mode,
  input  logic [1:0]    rj_len,
  output logic [SW-1:0] smp_left,
  output logic [SW-1:0] smp_right,
  output logic          smp_valid,
  output logic          zero_left,
  output logic          zero_right
);
  localparam int CW = $clog2(SW + 1);
  localparam int ZW = $clog2(ZERO_FRAMES + 2);
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [CW-1:0]    TOP     = CW'(SW - 1);

  logic [2:0]       s1, s2;
  logic             lr_q, ch_q, armed, have_left;
  logic [POS_W-1:0] pos_q, idx, start;
  logic [CW-1:0]    cnt_q;
  logic [SW-1:0]    acc_q, hold_q;
  logic [SW-1:0]    smp_q [2];
  logic [1:0]       zflag;

  wire dsp     = fmt_mode == 2'b11;
  wire lr      = s1[1];
  wire din     = s1[0];
  wire tick    = dsp ? (s2[2] & ~s1[2]) : (s1[2] & ~s2[2]);
  wire xfer    = dsp ? (lr & ~lr_q) : (lr ^ lr_q);
  wire next_ch = dsp ? ~ch_q : ((fmt_mode == 2'b01) ? lr : ~lr);
  wire room    = cnt_q < CW'(SW);
  wire commit  = tick & xfer & armed;
  wire fire    = commit & ch_q & have_left;
  wire [CW-1:0] wr_at = TOP - cnt_q;

  always_comb begin
    case (fmt_mode)
      2'b00: begin
        case (rj_len)
          2'b01:   start = POS_W'(12);
          2'b10:   start = POS_W'(16);
          default: start = POS_W'(8);
        endcase
      end
      2'b01:   start = POS_W'(1);
      default: start = '0;
    endcase
  end

  assign idx = (pos_q == POS_MAX) ? pos_q : pos_q + 1'b1;
  wire cap = armed & room & (dsp ? ~lr : (idx >= start));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= '0;
      s2    <= '0;
      lr_q  <= 1'b0;
      ch_q  <= 1'b1;
      armed <= 1'b0;
      pos_q <= '0;
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      s1 <= {bit_clk, frm_clk, ser_data};
      s2 <= s1;
      if (tick) begin
        lr_q <= lr;
        if (xfer) begin
          armed <= 1'b1;
          ch_q  <= next_ch;
          pos_q <= '0;
          if (!dsp && start == '0) begin
            acc_q <= {din, {(SW-1){1'b0}}};
            cnt_q <= CW'(1);
          end else begin
            acc_q <= '0;
            cnt_q <= '0;
          end
        end else begin
          pos_q <= idx;
          if (cap) begin
            acc_q[wr_at] <= din;
            cnt_q        <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      have_left <= 1'b0;
      smp_valid <= 1'b0;
      smp_q[0]  <= '0;
      smp_q[1]  <= '0;
    end else begin
      smp_valid <= fire;
      if (commit & ~ch_q) begin
        hold_q    <= acc_q;
        have_left <= 1'b1;
      end
      if (fire) begin
        smp_q[0]  <= hold_q;
        smp_q[1]  <= acc_q;
        have_left <= 1'b0;
      end
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_zero
    logic [ZW-1:0] zc_q, zc_n;
    logic          zf_q;
    wire [SW-1:0]  word = (c == 0) ? hold_q : acc_q;
    assign zc_n = (word != '0) ? '0 :
                  ((zc_q == ZW'(ZERO_FRAMES + 1)) ? zc_q : zc_q + 1'b1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        zc_q <= '0;
        zf_q <= 1'b0;
      end else if (fire) begin
        zc_q <= zc_n;
        zf_q <= zc_n > ZW'(ZERO_FRAMES);
      end
    end
    assign zflag[c] = zf_q;
  end

  assign smp_left   = smp_q[0];
  assign smp_right  = smp_q[1];
  assign zero_left  = zflag[0];
  assign zero_right = zflag[1];
endmodule

module serial_audio_rx_chk #(
  parameter int SW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    fmt_mode,
  input logic [1:0]    rj_len,
  input logic [SW-1:0] smp_left,
  input logic [SW-1:0] smp_right,
  input logic          smp_valid,
  input logic          zero_left,
  input logic          zero_right
);
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);
  a_r7_left_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> $stable(smp_left));
  a_r7_right_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> $stable(smp_right));
  a_r8_left_flag_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> $stable(zero_left));
  a_r8_right_flag_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> $stable(zero_right));
  a_r8_left_flag_means_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && zero_left) |-> smp_left == '0);
  a_r9_left_nonzero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_left != '0) |-> !zero_left);
  a_r9_right_nonzero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_right != '0) |-> !zero_right);
  a_r5_rj16_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && fmt_mode == 2'b00 && rj_len == 2'b10) |->
      (smp_left[SW-17:0] == '0 && smp_right[SW-17:0] == '0));
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_mode(fmt_mode), .rj_len(rj_len),
  .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid),
  .zero_left(zero_left), .zero_right(zero_right)
);

// File: tb/serial_audio_rx_tb.sv
`timescale 1ns/1ps
module serial_audio_rx_tb;
  localparam int ZF = 5;

  logic clk = 1'b0;
  logic rst_n, bck, wsel, sdi;
  logic [1:0] fmt, rjl;
  logic [23:0] smp_left, smp_right;
  logic smp_valid, zero_left, zero_right;

  always #2.5 clk = ~clk;

  serial_audio_rx #(.ZERO_FRAMES(ZF)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_clk(bck), .frm_clk(wsel), .ser_data(sdi),
    .fmt_mode(fmt), .rj_len(rjl),
    .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid),
    .zero_left(zero_left), .zero_right(zero_right)
  );

  logic [23:0] eq_l[$], eq_r[$];
  logic        eq_zl[$], eq_zr[$];
  string       eq_tag[$];
  int vec = 0, bad = 0, zcl = 0, zcr = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string what, input logic [23:0] act, input logic [23:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && smp_valid) begin
      vec++;
      if (eq_l.size() == 0) begin
        bad++;
        $display("FAIL R7 unexpected strobe: actual %h/%h expected none", smp_left, smp_right);
      end else begin
        logic [23:0] el, er;
        logic zl, zr;
        string t;
        el = eq_l.pop_front(); er = eq_r.pop_front();
        zl = eq_zl.pop_front(); zr = eq_zr.pop_front(); t = eq_tag.pop_front();
        if (smp_left !== el || smp_right !== er || zero_left !== zl || zero_right !== zr) begin
          bad++;
          $display("FAIL %s: actual L=%h R=%h zl=%b zr=%b expected L=%h R=%h zl=%b zr=%b",
                   t, smp_left, smp_right, zero_left, zero_right, el, er, zl, zr);
        end
      end
    end
  end

  task automatic bit_out(input logic l, input logic d);
    if (fmt == 2'b11) begin
      bck = 1'b1; wsel = l; sdi = d;
      repeat (2) @(negedge clk);
      bck = 1'b0;
      repeat (2) @(negedge clk);
    end else begin
      bck = 1'b0; wsel = l; sdi = d;
      repeat (2) @(negedge clk);
      bck = 1'b1;
      repeat (2) @(negedge clk);
    end
  endtask

  function automatic int rj_bits();
    case (rjl)
      2'b01:   return 20;
      2'b10:   return 16;
      default: return 24;
    endcase
  endfunction

  function automatic int data_off();
    case (fmt)
      2'b00:   return 32 - rj_bits();
      2'b10:   return 0;
      default: return 1;
    endcase
  endfunction

  task automatic send_half(input logic left, input logic [23:0] w, input int nb);
    int off = data_off();
    int n = (fmt == 2'b00) ? rj_bits() : nb;
    logic lv = (fmt == 2'b01) ? ~left : left;
    for (int i = 0; i < 32; i++) begin
      logic l, d;
      int k;
      k = i - off;
      l = (fmt == 2'b11) ? (i == 0) : lv;
      if (k < 0) d = 1'b1;
      else if (k < n) d = (k < 24) ? w[23-k] : 1'b1;
      else d = 1'b0;
      bit_out(l, d);
    end
  endtask

  task automatic frame(input logic [23:0] wl, input logic [23:0] wr, input int nb,
                       input bit keep, input string tag);
    if (keep) begin
      int n;
      logic [23:0] m, el, er;
      n  = (fmt == 2'b00) ? rj_bits() : ((nb > 24) ? 24 : nb);
      m  = ~((24'h1 << (24 - n)) - 24'h1);
      el = wl & m;
      er = wr & m;
      zcl = (el == 0) ? ((zcl > ZF) ? zcl : zcl + 1) : 0;
      zcr = (er == 0) ? ((zcr > ZF) ? zcr : zcr + 1) : 0;
      eq_l.push_back(el); eq_r.push_back(er);
      eq_zl.push_back(zcl > ZF); eq_zr.push_back(zcr > ZF);
      eq_tag.push_back(tag);
    end
    send_half(1'b1, wl, nb);
    send_half(1'b0, wr, nb);
  endtask

  task automatic start_group(input logic [1:0] m, input logic [1:0] l);
    rst_n = 1'b0; fmt = m; rjl = l; bck = 1'b0; wsel = (m == 2'b01); sdi = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1; zcl = 0; zcr = 0;
    repeat (4) bit_out(m == 2'b01, 1'b1);
  endtask

  task automatic end_group(input string tag);
    frame(24'h5a5a5a, 24'h5a5a5a, 24, 1'b0, "");
    repeat (8) @(negedge clk);
    chk(eq_l.size() == 0, {"R7 all frames strobed ", tag}, 24'(eq_l.size()), 24'h0);
    eq_l.delete(); eq_r.delete(); eq_zl.delete(); eq_zr.delete(); eq_tag.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog R7: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bck = 1'b0; wsel = 1'b0; sdi = 1'b1; fmt = 2'b10; rjl = 2'b00;
    repeat (3) @(negedge clk);
    chk(smp_left == 0, "R10 reset left", smp_left, 24'h0);
    chk(smp_right == 0, "R10 reset right", smp_right, 24'h0);
    chk({smp_valid, zero_left, zero_right} == 3'b000, "R10 reset strobe/flags",
        24'({smp_valid, zero_left, zero_right}), 24'h0);

    start_group(2'b10, 2'b00);
    frame(24'ha5a5a5, 24'h3c3c3c, 24, 1'b1, "R1 left-justified 24b");
    frame(24'h800001, 24'h7fffff, 24, 1'b1, "R1 left-justified extremes");
    frame(24'h123456, 24'hfedcba, 16, 1'b1, "R5 left-justified 16b");
    frame(24'h9abcde, 24'h13579b, 28, 1'b1, "R6 left-justified 28b dropped");
    frame(24'hc0ffee, 24'h0badf0, 20, 1'b1, "R5 left-justified 20b");
    end_group("R1");

    start_group(2'b01, 2'b00);
    frame(24'h876543, 24'h2468ac, 24, 1'b1, "R2 I2S 24b");
    frame(24'hffffff, 24'h000001, 24, 1'b1, "R2 I2S extremes");
    frame(24'h345678, 24'habcdef, 18, 1'b1, "R5 I2S 18b");
    frame(24'h55aa55, 24'haa55aa, 27, 1'b1, "R6 I2S 27b dropped");
    end_group("R2");

    for (int c = 0; c < 4; c++) begin
      start_group(2'b00, 2'(c));
      frame(24'hdeadbe, 24'h1234ff, 24, 1'b1, "R3 right-justified offset");
      frame(24'h7f00ff, 24'h80ff01, 24, 1'b1, "R3 R5 right-justified length");
      end_group("R3");
    end

    start_group(2'b11, 2'b00);
    frame(24'h112233, 24'hccbbaa, 24, 1'b1, "R4 DSP 24b");
    frame(24'hfedcba, 24'h010203, 20, 1'b1, "R4 R5 DSP 20b");
    frame(24'h6789ab, 24'h9876fe, 27, 1'b1, "R4 R6 DSP 27b dropped");
    end_group("R4");

    start_group(2'b10, 2'b00);
    for (int k = 0; k < 12; k++)
      frame((k == 8) ? 24'h000100 : 24'h0, (k < 2) ? 24'h00ff00 : 24'h0, 24, 1'b1,
            (k == 8) ? "R9 nonzero clears flag" : "R8 zero run flag");
    end_group("R8");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule